// File: doc/BRIEF.md
# Variable-Length Serial Shift Channel

This block is one synchronous serial channel. A single 9-bit shift register sends a word out on `sout` and, in the same transfer, collects a word from `sin`. Software never reaches the shift register directly. All access goes through a 16-bit data register on a simple register bus. The low 9 bits of that register are the transfer buffer. The upper 7 bits, `D`, set the shift-clock rate.

A transfer starts when software writes the low byte lane while the channel is enabled and idle. The word length comes from a two-bit select and is 7, 8 or 9 bits. A bit-order input picks whether the least or the most significant bit goes first. The parallel word always sits right-aligned at bit 0. When the last bit has shifted, the received word replaces the buffer bits. Every bit above the word length is cleared, and a one-cycle `done` pulse marks the end of the transfer. An `overrun` flag reports a received word that arrived before the previous one was read.

Top module: `vlsc_channel`

## Requirements
- R1: After synchronous reset, `rd_data` is 0x0000 and `busy`, `done`, `sclk`, `sout` and `overrun` are all 0.
- R2: A write with `wr_be`=2'b11 while idle stores all 16 bits, and the new value appears on `rd_data` in the next cycle.
- R3: A write with `wr_be`=2'b01 while `ch_en`=0 stores bits 7:0, clears bits 15:9, keeps bit 8 and starts no transfer. A write with `wr_be`=2'b10 stores bits 15:8 only.
- R4: A write that includes the low lane (`wr_be[0]`=1) while `ch_en`=1 and idle starts a transfer. `busy` is high from the next cycle for exactly N·2·(D+1) cycles, where D = data register bits 15:9 after the write.
- R5: For each bit, `sclk` is low for D+1 cycles and then high for D+1 cycles. It is low whenever the channel is idle.
- R6: `len_sel` encoding: 2'b10 = 7 bits, 2'b11 = 8 bits, 2'b01 = 9 bits, 2'b00 = 8 bits. A transfer gives exactly N rising `sclk` edges.
- R7: With `bit_msb_first`=0, bit 0 of the word goes out first. With 1, bit N-1 goes out first. `sout` changes only when a bit begins, never while `sclk` is high, and is 0 while idle.
- R8: `sin` is sampled at each rising `sclk`. The received word is stored in bits N-1:0. The first bit lands in bit 0 for LSB-first and in bit N-1 for MSB-first. Bits N..8 are 0 and bits 15:9 are unchanged. The store happens in the cycle `busy` falls.
- R9: `done` is high for exactly one cycle: the first cycle with `busy` low after a completed transfer.
- R10: A bus write while `busy` is high has no effect on the data register or on the transfer.
- R11: `overrun` is set together with `done` when the previous received word was not read (`rd_en`). It stays set until the next `rd_en` without a new store.
- R12: Dropping `ch_en` during a transfer aborts it. `busy` and `sclk` are low in the next cycle, with no `done` and no store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operation clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | 1 | Channel enable |
| bit_msb_first | input | 1 | 1 = MSB first, 0 = LSB first |
| len_sel | input | 2 | Word length select |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte lanes: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe, marks the received word as read |
| rd_data | output | 16 | Data register contents |
| sin | input | 1 | Serial input |
| sout | output | 1 | Serial output |
| sclk | output | 1 | Shift clock |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| overrun | output | 1 | Unread received word was overwritten |

## Verification
A write changes `rd_data` one cycle after the edge that samples it. `busy` rises in that same cycle, and the first `sclk` rise follows D+1 cycles later. The stored word, the fall of `busy` and the `done` pulse all arrive together, N·2·(D+1) cycles after the start. `overrun` changes with `done`, and an abort shows one cycle after `ch_en` falls. A behavioural model in the bench advances on every rising edge, using only the inputs seen before that edge. The design's outputs are compared with it at the following falling edge, so every expectation is sampled in the cycle it becomes due.

// File: rtl/vlsc_pkg.sv
package vlsc_pkg;

    localparam int SH_W  = 9;
    localparam int DIV_W = 7;
    localparam int REG_W = SH_W + DIV_W;
    localparam int CNT_W = 4;
    localparam int LO_W  = 8;

    typedef enum logic [1:0] {
        LEN_RSV = 2'b00,
        LEN_9B  = 2'b01,
        LEN_7B  = 2'b10,
        LEN_8B  = 2'b11
    } len_sel_e;

    typedef struct packed {
        logic [CNT_W-1:0] nbits;
        logic             msb_first;
    } frame_cfg_t;

    function automatic logic [CNT_W-1:0] len_decode(input logic [1:0] sel);
        case (len_sel_e'(sel))
            LEN_7B:  return CNT_W'(7);
            LEN_9B:  return CNT_W'(9);
            default: return CNT_W'(8);
        endcase
    endfunction

    function automatic logic [SH_W-1:0] len_mask(input logic [CNT_W-1:0] n);
        logic [SH_W-1:0] m;
        for (int i = 0; i < SH_W; i++) m[i] = (i < int'(n));
        return m;
    endfunction

endpackage

// File: rtl/vlsc_baud.sv
module vlsc_baud
    import vlsc_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic          rise_tick,
    output logic          fall_tick,
    output logic          phase
);
    logic [DW-1:0] cnt_q;
    logic [DW-1:0] div_q;
    logic          wrap;

    assign wrap      = run && (cnt_q == div_q);
    assign rise_tick = wrap && !phase;
    assign fall_tick = wrap && phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            div_q <= '0;
            phase <= 1'b0;
        end else if (load || !run) begin
            cnt_q <= '0;
            phase <= 1'b0;
            if (load) div_q <= div;
        end else if (wrap) begin
            cnt_q <= '0;
            phase <= ~phase;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/vlsc_shifter.sv
module vlsc_shifter
    import vlsc_pkg::*;
#(
    parameter int W = SH_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  frame_cfg_t   cfg,
    input  logic         rise_tick,
    input  logic         fall_tick,
    input  logic         sin,
    output logic         busy,
    output logic         done,
    output logic         sout,
    output logic         fin,
    output logic [W-1:0] fin_word
);
    logic [W-1:0]     sh_q;
    logic [W-1:0]     mask_q;
    logic [W-1:0]     lsb_next;
    logic [W-1:0]     msb_next;
    logic [CNT_W-1:0] bitcnt_q;
    frame_cfg_t       cfg_q;
    logic             smp_q;
    logic             last;

    always_comb begin
        mask_q = len_mask(cfg_q.nbits);
        lsb_next = sh_q >> 1;
        lsb_next[cfg_q.nbits - CNT_W'(1)] = smp_q;
        msb_next = {sh_q[W-2:0], smp_q} & mask_q;
    end

    assign last     = (bitcnt_q == cfg_q.nbits - CNT_W'(1));
    assign fin      = busy && en && fall_tick && last;
    assign fin_word = cfg_q.msb_first ? msb_next : lsb_next;
    assign sout     = busy && (cfg_q.msb_first ? sh_q[cfg_q.nbits - CNT_W'(1)] : sh_q[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q     <= '0;
            bitcnt_q <= '0;
            cfg_q    <= '0;
            smp_q    <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                sh_q     <= load_word & len_mask(cfg.nbits);
                cfg_q    <= cfg;
                bitcnt_q <= '0;
                busy     <= 1'b1;
            end else if (busy && !en) begin
                busy <= 1'b0;
            end else if (busy) begin
                if (rise_tick) smp_q <= sin;
                if (fall_tick) begin
                    sh_q <= fin_word;
                    if (last) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/vlsc_databuf.sv
module vlsc_databuf
    import vlsc_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int SW = SH_W,
    parameter int LW = LO_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          busy,
    input  logic          wr_en,
    input  logic [1:0]    wr_be,
    input  logic [RW-1:0] wr_data,
    input  logic          rd_en,
    input  logic          fin,
    input  logic [SW-1:0] fin_word,
    output logic [RW-1:0] data_q,
    output logic [RW-1:0] merged,
    output logic          start,
    output logic          ovr
);
    logic accept;
    logic unread_q;

    always_comb begin
        merged = data_q;
        case (wr_be)
            2'b11: merged = wr_data;
            2'b01: begin
                merged[LW-1:0] = wr_data[LW-1:0];
                if (!en) merged[RW-1:SW] = '0;
            end
            2'b10: merged[RW-1:LW] = wr_data[RW-1:LW];
            default: ;
        endcase
    end

    assign accept = wr_en && !busy;
    assign start  = accept && en && wr_be[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q   <= '0;
            unread_q <= 1'b0;
            ovr      <= 1'b0;
        end else begin
            if (fin)         data_q[SW-1:0] <= fin_word;
            else if (accept) data_q <= merged;
            if (fin) begin
                ovr      <= unread_q && !rd_en;
                unread_q <= 1'b1;
            end else if (rd_en) begin
                ovr      <= 1'b0;
                unread_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/vlsc_channel.sv
module vlsc_channel
    import vlsc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ch_en,
    input  logic        bit_msb_first,
    input  logic [1:0]  len_sel,
    input  logic        wr_en,
    input  logic [1:0]  wr_be,
    input  logic [15:0] wr_data,
    input  logic        rd_en,
    output logic [15:0] rd_data,
    input  logic        sin,
    output logic        sout,
    output logic        sclk,
    output logic        busy,
    output logic        done,
    output logic        overrun
);
    logic [REG_W-1:0] merged;
    logic             start;
    logic             fin;
    logic [SH_W-1:0]  fin_word;
    logic             rise_tick;
    logic             fall_tick;
    logic             phase;
    frame_cfg_t       cfg;

    assign cfg.nbits     = len_decode(len_sel);
    assign cfg.msb_first = bit_msb_first;
    assign sclk          = phase && busy;

    vlsc_databuf u_buf (
        .clk(clk), .rst(rst), .en(ch_en), .busy(busy),
        .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data), .rd_en(rd_en),
        .fin(fin), .fin_word(fin_word),
        .data_q(rd_data), .merged(merged), .start(start), .ovr(overrun)
    );

    vlsc_baud u_baud (
        .clk(clk), .rst(rst), .load(start), .run(busy),
        .div(merged[REG_W-1:SH_W]),
        .rise_tick(rise_tick), .fall_tick(fall_tick), .phase(phase)
    );

    vlsc_shifter u_sh (
        .clk(clk), .rst(rst), .en(ch_en), .load(start),
        .load_word(merged[SH_W-1:0]), .cfg(cfg),
        .rise_tick(rise_tick), .fall_tick(fall_tick), .sin(sin),
        .busy(busy), .done(done), .sout(sout), .fin(fin), .fin_word(fin_word)
    );
endmodule

// File: rtl/vlsc_channel_chk.sv
module vlsc_channel_chk (
    input logic        clk,
    input logic        rst,
    input logic        ch_en,
    input logic        bit_msb_first,
    input logic [1:0]  len_sel,
    input logic        wr_en,
    input logic [1:0]  wr_be,
    input logic [15:0] wr_data,
    input logic        rd_en,
    input logic [15:0] rd_data,
    input logic        sin,
    input logic        sout,
    input logic        sclk,
    input logic        busy,
    input logic        done,
    input logic        overrun
);
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    a_r5_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk);

    a_r7_sout_steady_high: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(busy)) |-> $stable(sout));

    a_r10_write_busy_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en) |=> (done || rd_data == $past(rd_data)));

    a_r11_overrun_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> done);

    a_r3_low_write_clears_div: assert property (@(posedge clk) disable iff (rst)
        (!ch_en && !busy && wr_en && wr_be == 2'b01) |=> (rd_data[15:9] == 7'd0 && !busy));

    a_r12_abort: assert property (@(posedge clk) disable iff (rst)
        (busy && !ch_en) |=> (!busy && !done && !sclk));
endmodule

bind vlsc_channel vlsc_channel_chk u_chk (.*);

// File: tb/vlsc_channel_tb.sv
module vlsc_channel_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ch_en = 1'b0;
    logic        bit_msb_first = 1'b0;
    logic [1:0]  len_sel = 2'b11;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_be = 2'b00;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        sin = 1'b0;
    logic [15:0] rd_data;
    logic        sout, sclk, busy, done, overrun;

    always #2 clk = ~clk;

    vlsc_channel u_dut (.*);

    int n_chk = 0, n_err = 0, cyc = 0, rises = 0;
    bit summarised = 0, sin_one = 0, last_sclk = 0;
    logic [15:0] lfsr = 16'hACE1;

    // behavioural reference state
    int m_busy, m_done, m_phase, m_cnt, m_bit, m_N, m_D, m_msb, m_k, m_unread, m_ovr, ob, store;
    logic [8:0]  m_tx, m_rx;
    logic [15:0] m_buf, nb;

    function automatic int nlen(input logic [1:0] s);
        if (s == 2'b10) return 7;
        if (s == 2'b01) return 9;
        return 8;
    endfunction

    task automatic check(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic summary();
        if (!summarised) begin
            summarised = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        end
    endtask

    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        sin  <= sin_one ? 1'b1 : lfsr[0];
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
        if (rst) begin
            m_busy = 0; m_done = 0; m_phase = 0; m_cnt = 0; m_bit = 0; m_k = 0;
            m_N = 8; m_D = 0; m_msb = 0; m_unread = 0; m_ovr = 0;
            m_tx = '0; m_rx = '0; m_buf = '0;
        end else begin
            ob = m_busy; m_done = 0; store = 0;
            if (m_busy != 0) begin
                if (!ch_en) m_busy = 0;
                else if (m_cnt == m_D) begin
                    m_cnt = 0;
                    if (m_phase == 0) begin
                        m_phase = 1;
                        if (m_msb != 0) m_rx[m_N-1-m_k] = sin; else m_rx[m_k] = sin;
                        m_k++;
                    end else begin
                        m_phase = 0;
                        if (m_bit == m_N - 1) begin m_busy = 0; m_done = 1; store = 1; end
                        else m_bit++;
                    end
                end else m_cnt++;
            end
            if (store != 0) begin
                m_buf[8:0] = m_rx;
                m_ovr = (m_unread != 0 && !rd_en) ? 1 : 0;
                m_unread = 1;
            end else if (rd_en) begin
                m_unread = 0; m_ovr = 0;
            end
            if (wr_en && ob == 0) begin
                nb = m_buf;
                if (wr_be == 2'b11) nb = wr_data;
                else if (wr_be == 2'b01) begin
                    nb[7:0] = wr_data[7:0];
                    if (!ch_en) nb[15:9] = '0;
                end else if (wr_be == 2'b10) nb[15:8] = wr_data[15:8];
                m_buf = nb;
                if (ch_en && wr_be[0]) begin
                    m_busy = 1; m_cnt = 0; m_phase = 0; m_bit = 0; m_k = 0; m_rx = '0;
                    m_N = nlen(len_sel); m_D = int'(nb[15:9]); m_msb = int'(bit_msb_first);
                    m_tx = '0;
                    for (int i = 0; i < m_N; i++) m_tx[i] = nb[i];
                end
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check(int'(busy), m_busy, "R4 busy");
            check(int'(done), m_done, "R9 done");
            check(int'(sclk), (m_busy != 0 && m_phase != 0) ? 1 : 0, "R5 sclk");
            check(int'(sout), (m_busy == 0) ? 0 : int'(m_tx[(m_msb != 0) ? m_N-1-m_bit : m_bit]), "R7 sout");
            check(int'(rd_data), int'(m_buf), "R8 rd_data");
            check(int'(overrun), m_ovr, "R11 overrun");
            if (sclk && !last_sclk) rises++;
            last_sclk = sclk;
        end
    end

    task automatic wr(input logic [1:0] be, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; wr_be = be; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_be = 2'b00;
    endtask

    task automatic rd();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic xfer(input int d, input logic [1:0] ls, input logic msb, input logic [8:0] w);
        @(negedge clk); ch_en = 1'b1; len_sel = ls; bit_msb_first = msb; rises = 0;
        wr(2'b11, {7'(d), w});
        while (busy) @(negedge clk);
        @(negedge clk);
        check(rises, nlen(ls), "R6 sclk rises per word");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(int'(rd_data), 0, "R1 reset data");
        check(int'({busy, done, sclk, sout, overrun}), 0, "R1 reset flags");

        wr(2'b11, 16'h0555);
        check(int'(rd_data), 16'h0555, "R2 full write");
        wr(2'b01, 16'h00AB);
        check(int'(rd_data), 16'h01AB, "R3 low write stopped");
        check(int'(busy), 0, "R3 no transfer");
        wr(2'b10, 16'h0400);
        check(int'(rd_data), 16'h04AB, "R3 high lane write");

        xfer(1, 2'b11, 1'b0, 9'h0A5);
        rd();
        sin_one = 1;
        xfer(2, 2'b10, 1'b1, 9'h1FF);
        check(int'(rd_data), int'({7'd2, 9'h07F}), "R8 zero fill above 7 bits");
        rd();
        sin_one = 0;
        xfer(0, 2'b01, 1'b0, 9'h1C3);
        xfer(3, 2'b00, 1'b1, 9'h0F0);
        check(int'(overrun), 1, "R11 overrun set");
        rd();
        check(int'(overrun), 0, "R11 overrun cleared by read");

        // R10: write during a transfer
        @(negedge clk); len_sel = 2'b11; bit_msb_first = 1'b0;
        wr(2'b11, {7'd1, 9'h03C});
        repeat (5) @(negedge clk);
        wr(2'b11, 16'hFFFF);
        while (busy) @(negedge clk);
        check(int'(rd_data[15:9]), 1, "R10 write while busy ignored");
        rd();

        // R12: abort
        wr(2'b11, {7'd2, 9'h155});
        repeat (10) @(negedge clk);
        ch_en = 1'b0;
        @(negedge clk);
        check(int'(busy), 0, "R12 abort busy");
        check(int'(done), 0, "R12 abort no done");
        check(int'(rd_data), int'({7'd2, 9'h155}), "R12 abort no store");
        repeat (4) @(negedge clk);

        summary();
        $finish;
    end
endmodule